// File: doc/BRIEF.md
# Bit-Loading Subcarrier Distributor

This block sits in front of a QAM constellation mapper in a multicarrier transmitter. It takes one serial data bit per accepted transfer and cuts the stream into bit groups, one for each subcarrier of a frame. The subcarriers are visited in ascending order, and the size of each group comes from a bit allocation table.

The table holds one entry of 0 to 15 bits for each of the 256 subcarriers. Software loads it through a small write port while the datapath is held off and idle. After that the table stays frozen while data flows, so every frame consumes the same total number of bits. Each group leaves on a valid/ready output as a subcarrier index, a bit count and a 15-bit packed field. A start flag marks the first subcarrier of a frame and an end flag marks the last. A subcarrier with a zero entry still produces a group, flagged as empty, so the mapper's indexing never slips.

Top module: `bitload_dist`

## Requirements
- R1: After reset, `out_valid` is low and every table entry is zero. A frame run on that table therefore gives 256 empty groups and consumes no input bits.
- R2: A write with `cfg_en` and `cfg_wr` both high while the block is idle sets table entry `cfg_addr` to `cfg_bits`. Idle means the next group is subcarrier 0, no bits of it have been collected yet, and `out_valid` is low.
- R3: While `cfg_en` is high, `in_ready` is low and no new group is loaded into the output.
- R4: A table write made while the block is not idle is ignored. The frame in progress and later frames keep the old entry.
- R5: Groups come out with indices 0, 1, ..., 255 and then wrap back to 0.
- R6: Each group's `out_count` equals the table entry for its subcarrier, and the group consumes exactly that many input bits.
- R7: Bits are packed LSB-first. The first bit received for a group goes in `out_bits[0]`, and every bit at position `out_count` or above is zero.
- R8: A subcarrier with a zero entry takes no input bits. It emits a group with `out_count` 0 and `out_empty` high.
- R9: `out_sof` is high exactly on the group for subcarrier 0, and `out_eof` is high exactly on the group for subcarrier 255.
- R10: While `out_valid` is high and `out_ready` is low, the output group stays unchanged and `in_ready` is low.
- R11: The number of input bits accepted over one frame equals the sum of all table entries.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_en | input | 1 | Configuration mode; holds the datapath |
| cfg_wr | input | 1 | Table write strobe |
| cfg_addr | input | 8 | Subcarrier index to write |
| cfg_bits | input | 4 | Bit count for that subcarrier |
| in_valid | input | 1 | Input bit valid |
| in_bit | input | 1 | Serial data bit |
| in_ready | output | 1 | Input bit accepted when high with in_valid |
| out_valid | output | 1 | Group valid |
| out_ready | input | 1 | Downstream accepts the group |
| out_index | output | 8 | Subcarrier index of the group |
| out_count | output | 4 | Number of bits in the group |
| out_bits | output | 15 | Packed bits, LSB-first, zero above count |
| out_empty | output | 1 | Group carries no bits |
| out_sof | output | 1 | Group is subcarrier 0 |
| out_eof | output | 1 | Group is subcarrier 255 |

## Verification
The hardest cases to reach from the ports are table writes at the exact frame boundary and in the middle of a frame. The block is idle only in the single cycle after the last group has gone out and before subcarrier 0 collects its first bit or emits its empty group. To reach it, the stimulus raises `cfg_en` on the same edge that the end-of-frame group is accepted, which freezes the datapath at the boundary. It does the same at an arbitrary mid-frame group to show that writes made there are ignored. Random valid and ready patterns run around these pauses, and the tables mix zero and full-width entries.

// File: rtl/bitload_pkg.sv
package bitload_pkg;
  localparam int unsigned DEF_NUM_SC = 256;
  localparam int unsigned DEF_CNT_W  = 4;

  function automatic int unsigned max_bits(int unsigned cnt_w);
    return (1 << cnt_w) - 1;
  endfunction
endpackage

// File: rtl/bitload_table.sv
module bitload_table #(
  parameter int unsigned NUM_SC = 256,
  parameter int unsigned CNT_W  = 4,
  localparam int unsigned IDX_W = $clog2(NUM_SC)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_addr,
  input  logic [CNT_W-1:0] wr_data,
  input  logic [IDX_W-1:0] rd_addr,
  output logic [CNT_W-1:0] rd_data
);
  logic [CNT_W-1:0] entry_q [NUM_SC];

  for (genvar g = 0; g < NUM_SC; g++) begin : g_entry
    logic hit;
    assign hit = wr_en && (wr_addr == IDX_W'(g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   entry_q[g] <= '0;
      else if (hit) entry_q[g] <= wr_data;
    end
  end

  assign rd_data = entry_q[rd_addr];
endmodule

// File: rtl/bitload_gather.sv
module bitload_gather #(
  parameter int unsigned NUM_SC = 256,
  parameter int unsigned CNT_W  = 4,
  localparam int unsigned IDX_W = $clog2(NUM_SC),
  localparam int unsigned MAX_BITS = bitload_pkg::max_bits(CNT_W)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                hold,
  input  logic                slot_free,
  input  logic [CNT_W-1:0]    need,
  input  logic                in_valid,
  input  logic                in_bit,
  output logic                in_ready,
  output logic [IDX_W-1:0]    sc_idx,
  output logic                emit,
  output logic [MAX_BITS-1:0] emit_bits,
  output logic                at_start
);
  logic [IDX_W-1:0]    idx_q, idx_d;
  logic [CNT_W-1:0]    cnt_q, cnt_d;
  logic [MAX_BITS-1:0] acc_q, acc_d;
  logic                full, last, take;
  logic [MAX_BITS-1:0] merged;

  always_comb begin
    full     = (cnt_q == need);
    last     = ({1'b0, cnt_q} + 1'b1) == {1'b0, need};
    in_ready = !hold && slot_free && !full;
    take     = in_valid && in_ready;
    merged   = acc_q | (take ? (MAX_BITS'(in_bit) << cnt_q) : '0);
    emit     = !hold && slot_free && (full || (take && last));
    idx_d    = idx_q;
    cnt_d    = cnt_q;
    acc_d    = acc_q;
    if (emit) begin
      idx_d = (idx_q == IDX_W'(NUM_SC - 1)) ? '0 : idx_q + 1'b1;
      cnt_d = '0;
      acc_d = '0;
    end else if (take) begin
      cnt_d = cnt_q + 1'b1;
      acc_d = merged;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q <= '0;
      cnt_q <= '0;
      acc_q <= '0;
    end else begin
      idx_q <= idx_d;
      cnt_q <= cnt_d;
      acc_q <= acc_d;
    end
  end

  assign sc_idx    = idx_q;
  assign emit_bits = merged;
  assign at_start  = (idx_q == '0) && (cnt_q == '0);

  AST_NO_OVERRUN: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q == '0) || (cnt_q < need)); // R6
endmodule

// File: rtl/bitload_outreg.sv
module bitload_outreg #(
  parameter int unsigned NUM_SC = 256,
  parameter int unsigned CNT_W  = 4,
  localparam int unsigned IDX_W = $clog2(NUM_SC),
  localparam int unsigned MAX_BITS = bitload_pkg::max_bits(CNT_W)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                load,
  input  logic [IDX_W-1:0]    d_idx,
  input  logic [CNT_W-1:0]    d_cnt,
  input  logic [MAX_BITS-1:0] d_bits,
  input  logic                out_ready,
  output logic                slot_free,
  output logic                out_valid,
  output logic [IDX_W-1:0]    out_index,
  output logic [CNT_W-1:0]    out_count,
  output logic [MAX_BITS-1:0] out_bits
);
  logic valid_q, valid_d;

  always_comb begin
    slot_free = !valid_q || out_ready;
    valid_d   = valid_q;
    if (load)           valid_d = 1'b1;
    else if (out_ready) valid_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) valid_q <= 1'b0;
    else        valid_q <= valid_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_index <= '0;
      out_count <= '0;
      out_bits  <= '0;
    end else if (load) begin
      out_index <= d_idx;
      out_count <= d_cnt;
      out_bits  <= d_bits;
    end
  end

  assign out_valid = valid_q;

  AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_index)
      && $stable(out_count) && $stable(out_bits)); // R10
  AST_HIGH_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> ((out_bits >> out_count) == '0)); // R7
endmodule

// File: rtl/bitload_dist.sv
module bitload_dist #(
  parameter int unsigned NUM_SC = bitload_pkg::DEF_NUM_SC,
  parameter int unsigned CNT_W  = bitload_pkg::DEF_CNT_W,
  localparam int unsigned IDX_W = $clog2(NUM_SC),
  localparam int unsigned MAX_BITS = bitload_pkg::max_bits(CNT_W)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cfg_en,
  input  logic                cfg_wr,
  input  logic [IDX_W-1:0]    cfg_addr,
  input  logic [CNT_W-1:0]    cfg_bits,
  input  logic                in_valid,
  input  logic                in_bit,
  output logic                in_ready,
  output logic                out_valid,
  input  logic                out_ready,
  output logic [IDX_W-1:0]    out_index,
  output logic [CNT_W-1:0]    out_count,
  output logic [MAX_BITS-1:0] out_bits,
  output logic                out_empty,
  output logic                out_sof,
  output logic                out_eof
);
  logic [IDX_W-1:0]    sc_idx;
  logic [CNT_W-1:0]    need;
  logic                slot_free, emit, at_start, idle, tbl_we;
  logic [MAX_BITS-1:0] emit_bits;

  assign idle   = at_start && !out_valid;
  assign tbl_we = cfg_en && cfg_wr && idle;

  bitload_table #(.NUM_SC(NUM_SC), .CNT_W(CNT_W)) u_table (
    .clk(clk), .rst_n(rst_n), .wr_en(tbl_we), .wr_addr(cfg_addr),
    .wr_data(cfg_bits), .rd_addr(sc_idx), .rd_data(need));

  bitload_gather #(.NUM_SC(NUM_SC), .CNT_W(CNT_W)) u_gather (
    .clk(clk), .rst_n(rst_n), .hold(cfg_en), .slot_free(slot_free),
    .need(need), .in_valid(in_valid), .in_bit(in_bit), .in_ready(in_ready),
    .sc_idx(sc_idx), .emit(emit), .emit_bits(emit_bits), .at_start(at_start));

  bitload_outreg #(.NUM_SC(NUM_SC), .CNT_W(CNT_W)) u_out (
    .clk(clk), .rst_n(rst_n), .load(emit), .d_idx(sc_idx), .d_cnt(need),
    .d_bits(emit_bits), .out_ready(out_ready), .slot_free(slot_free),
    .out_valid(out_valid), .out_index(out_index), .out_count(out_count),
    .out_bits(out_bits));

  assign out_empty = (out_count == '0);
  assign out_sof   = (out_index == '0);
  assign out_eof   = (out_index == IDX_W'(NUM_SC - 1));

  AST_CFG_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_en |-> !in_ready); // R3
  AST_CFG_NO_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_en && !out_valid |=> !out_valid); // R3
  AST_BACKPRESSURE: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |-> !in_ready); // R10
endmodule

// File: tb/bitload_dist_test.sv
module bitload_dist_test;
  localparam int NSC = 256;

  logic clk = 1'b0;
  logic rst_n;
  logic cfg_en, cfg_wr;
  logic [7:0] cfg_addr;
  logic [3:0] cfg_bits;
  logic in_valid, in_bit, in_ready;
  logic out_valid, out_ready;
  logic [7:0] out_index;
  logic [3:0] out_count;
  logic [14:0] out_bits;
  logic out_empty, out_sof, out_eof;

  always #2 clk = ~clk;

  bitload_dist uut (
    .clk(clk), .rst_n(rst_n), .cfg_en(cfg_en), .cfg_wr(cfg_wr),
    .cfg_addr(cfg_addr), .cfg_bits(cfg_bits), .in_valid(in_valid),
    .in_bit(in_bit), .in_ready(in_ready), .out_valid(out_valid),
    .out_ready(out_ready), .out_index(out_index), .out_count(out_count),
    .out_bits(out_bits), .out_empty(out_empty), .out_sof(out_sof),
    .out_eof(out_eof));

  int nchk = 0, nfail = 0;
  int shadow [NSC];
  int wr_ptr = 0, rd_ptr = 0, frame_base = 0, exp_idx = 0, frames_done = 0;
  bit run = 0, paused = 0, pause_eof = 0, pause_mid = 0, finished = 0;
  bit was_stalled = 0;
  logic [7:0] s_idx; logic [3:0] s_cnt; logic [14:0] s_bits;

  function automatic logic bit_of(int i);
    logic [31:0] h;
    h = i * 32'h9E3779B1;
    return h[17] ^ h[29];
  endfunction

  function automatic int frame_sum();
    int s = 0;
    for (int k = 0; k < NSC; k++) s += shadow[k];
    return s;
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic check_group();
    int n = shadow[exp_idx];
    logic [14:0] eb = '0;
    for (int k = 0; k < n; k++) eb[k] = bit_of(rd_ptr + k);
    chk(out_index == 8'(exp_idx), "R5 index", out_index, exp_idx);
    chk(out_count == 4'(n), "R6 count", out_count, n);
    chk(out_bits == eb, "R7 packed bits", out_bits, eb);
    chk(out_empty == (n == 0), "R8 empty flag", out_empty, n == 0);
    chk(out_sof == (exp_idx == 0), "R9 sof", out_sof, exp_idx == 0);
    chk(out_eof == (exp_idx == NSC - 1), "R9 eof", out_eof, exp_idx == NSC - 1);
    rd_ptr += n;
    if (exp_idx == NSC - 1) begin
      chk(wr_ptr - frame_base == frame_sum(), "R11 bits per frame", wr_ptr - frame_base, frame_sum());
      frame_base = wr_ptr;
      frames_done++;
    end
    exp_idx = (exp_idx + 1) % NSC;
  endtask

  always @(negedge clk) begin
    if (run && !paused) begin
      bit pause_now;
      pause_now = 0;
      out_ready = ($urandom % 4) != 0;
      #1;
      if (out_valid && !out_ready)
        chk(in_ready == 1'b0, "R10 in_ready under stall", in_ready, 0);
      if (was_stalled)
        chk(out_index == s_idx && out_count == s_cnt && out_bits == s_bits,
            "R10 held group", out_bits, s_bits);
      was_stalled = out_valid && !out_ready;
      s_idx = out_index; s_cnt = out_count; s_bits = out_bits;
      if (out_valid && out_ready) begin
        if ((pause_eof && exp_idx == NSC - 1) || (pause_mid && exp_idx == 100))
          pause_now = 1;
        check_group();
      end
      if (pause_now) begin
        in_valid = 0;
        cfg_en = 1;
        paused = 1;
        pause_eof = 0;
        pause_mid = 0;
      end else begin
        in_valid = ($urandom % 3) != 0;
        in_bit = bit_of(wr_ptr);
        #1;
        if (in_valid && in_ready) wr_ptr++;
      end
    end
  end

  task automatic cfg_write(input int a, input int v);
    @(negedge clk);
    cfg_wr = 1; cfg_addr = 8'(a); cfg_bits = 4'(v);
    @(negedge clk);
    cfg_wr = 0;
  endtask

  task automatic wait_pause();
    while (!paused) @(posedge clk);
    @(negedge clk);
    out_ready = 0;
    was_stalled = 0;
  endtask

  task automatic resume();
    @(posedge clk); #1;
    cfg_en = 0;
    paused = 0;
  endtask

  initial begin
    void'($urandom(32'd20240611));
    rst_n = 0; cfg_en = 1; cfg_wr = 0; cfg_addr = 0; cfg_bits = 0;
    in_valid = 0; in_bit = 0; out_ready = 0;
    for (int k = 0; k < NSC; k++) shadow[k] = 0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    @(negedge clk);
    chk(out_valid == 0, "R1 reset out_valid", out_valid, 0);
    chk(in_ready == 0, "R3 in_ready with cfg_en", in_ready, 0);

    // frame 0 on the reset table: all empty (R1, R8)
    pause_eof = 1;
    @(posedge clk); #1 cfg_en = 0; run = 1;
    wait_pause();
    chk(wr_ptr == 0, "R1 no bits on reset table", wr_ptr, 0);

    // load a full table at the frame boundary (R2)
    for (int k = 0; k < NSC; k++) begin
      int v = $urandom % 16;
      if (k == 0 || (k >= 10 && k < 20)) v = 0;
      if (k == NSC - 1 || k == 1) v = 15;
      shadow[k] = v;
      cfg_write(k, v);
    end
    pause_eof = 1;
    resume();
    wait_pause();

    // boundary edits (R2): first full, last empty
    shadow[0] = 15; cfg_write(0, 15);
    shadow[NSC-1] = 0; cfg_write(NSC - 1, 0);
    shadow[128] = 1; cfg_write(128, 1);
    pause_mid = 1;
    resume();
    wait_pause();

    // mid-frame writes must be ignored (R4); datapath held (R3)
    cfg_write(200, (shadow[200] + 5) % 16);
    cfg_write(0, 3);
    repeat (4) begin
      @(negedge clk);
      chk(in_ready == 0, "R3 in_ready held", in_ready, 0);
      chk(out_valid == 0, "R3 no group while held", out_valid, 0);
    end
    pause_eof = 1;
    resume();
    wait_pause();
    chk(frames_done == 3, "R5 frame count", frames_done, 3);

    run = 0;
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      nchk++; nfail++;
      $display("FAIL watchdog R5 actual=%0d expected=%0d", frames_done, 3);
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
    end
  end
endmodule